// File: doc/BRIEF.md
# Direct-Mapped Page Translation Buffer with Hashed Table Walk

This block turns an effective address into a real address for one access at a time. The caller supplies a 24-bit virtual segment identifier and a 32-bit effective address. Bits [27:12] of the address form a 16-bit page index. The block holds 64 cached translations in a direct-mapped buffer, and the low six bits of the page index select the slot. A lookup that hits returns a 20-bit real page number followed by the 12-bit byte offset, together with 2-bit protection bits. No memory access takes place on a hit.

On a miss the block searches a hashed page table in memory through a simple read port that returns one 32-bit word per request. It first searches the primary group of eight 8-byte entries, then the secondary group, whose hash is the bitwise complement of the primary hash. A matching entry is copied into the indexed slot and its translation is returned. When neither group holds a match, the block reports a page fault. A flush input clears every cached translation in a single cycle.

The table configuration word supplies two fields. The upper 16 bits give the table base, and the low 9 bits extend the hash mask, which sets the table size.

Top module: `ptlb_hash_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0, and every cached slot is empty, so the first access to any page starts a walk.
- R2: The buffer slot is selected by effective address bits [17:12]. A lookup hits only when that slot is valid, its stored segment identifier equals `req_vsid`, and its stored 16-bit page index equals address bits [27:12]. Address bits [31:28] take no part in the match. A hit issues no memory request.
- R3: A successful response drives `rsp_fault` to 0, `rsp_ra` to {real page number, effective address bits [11:0]}, and `rsp_pp` to the entry's 2-bit protection field.
- R4: The primary hash is the low 19 bits of the segment identifier XOR {3'b000, page index}. A group address is {cfg[31:16], 16'h0} OR ((hash AND {cfg[8:0], 10'h3FF}) shifted left by 6). The first memory read of a walk uses the primary group address.
- R5: The eight entries of a group are read in order, at group + 8*slot. Word 0 of an entry is at offset +0 and word 1 is at offset +4. Word 1 is read only when word 0 matches, so finding an entry at pass p and slot s costs 8p+s+2 word reads.
- R6: Word 0 is laid out as {bit 31 valid, bits 30:7 segment identifier, bit 6 hash select, bits 5:0 page index bits [15:10]}. An entry matches only when it is valid, its segment identifier is equal, its hash-select bit equals the pass number (0 primary, 1 secondary), and its abbreviated page index is equal.
- R7: After all eight primary entries miss, the secondary group is searched using the complemented hash.
- R8: When both groups miss, the response has `rsp_fault` = 1 after exactly 16 word reads. Nothing is written into the buffer.
- R9: A translation found in memory is written into the slot indexed by address bits [17:12]. A repeated access to the same page then hits. Word 1 is laid out as {bits 31:12 real page number, bits 1:0 protection}.
- R10: A page that shares a slot index with a cached page replaces the cached page. A later access to the replaced page walks memory again.
- R11: `flush` clears every valid bit in the following cycle. If a flush coincides with a refill write, the flush takes effect and the refilled translation is not kept, although the current response is still delivered.
- R12: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. After each accepted request, the block waits for one `mem_rsp_valid` word before it issues the next request.
- R13: `rsp_valid` is a single-cycle pulse. `req_ready` is high only while the block is idle, and it is high again in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| cfg_table | input | 32 | Table base in bits [31:16], mask extension in bits [8:0] |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vsid | input | 24 | Virtual segment identifier |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Page fault: no entry found in either group |
| rsp_ra | output | 32 | Real address |
| rsp_pp | output | 2 | Protection bits of the translation |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |

## Verification
The assertions assume the following about the block's inputs:
- The memory side returns exactly one data word for each accepted read, and never a word that was not requested.
- `cfg_table` stays constant while a walk is in progress, since the checks that the memory address is stable depend on it.

The bench meets these conditions with a single responder. The responder accepts a read after a random delay and returns one word after a second random delay. The bench programs the configuration once before the first request and never changes it. It also presents a new request only while `req_ready` is high.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
    localparam int VSID_W   = 24;
    localparam int PIDX_W   = 16;
    localparam int OFS_W    = 12;
    localparam int RPN_W    = 20;
    localparam int PP_W     = 2;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 6;
    localparam int ENTRIES  = 1 << IDX_W;
    localparam int SLOT_W   = 3;
    localparam int ENT_B    = 8;
    localparam int WORD_B   = 4;
    localparam int HASH_W   = 19;
    localparam int MASK_W   = 9;
    localparam int BASE_W   = 16;
    localparam int API_W    = 6;
    localparam int HASH_LOW_W = HASH_W - MASK_W;
    localparam int WSEL_LSB = $clog2(WORD_B);
    localparam int GRP_SH   = SLOT_W + $clog2(ENT_B);

    typedef struct packed {
        logic              vld;
        logic [VSID_W-1:0] vsid;
        logic [PIDX_W-1:0] pidx;
        logic [RPN_W-1:0]  rpn;
        logic [PP_W-1:0]   pp;
    } tlb_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_RD0,
        ST_WT0,
        ST_RD1,
        ST_WT1,
        ST_RESP
    } walk_st_t;
endpackage

// File: rtl/ptlb_array.sv
module ptlb_array
    import ptlb_pkg::*;
#(
    parameter int N_ENT = ENTRIES,
    localparam int IW   = $clog2(N_ENT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [IW-1:0] rd_idx,
    output tlb_ent_t      rd_ent,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  tlb_ent_t      wr_ent
);
    logic [N_ENT-1:0] vld_d, vld_q;
    tlb_ent_t         ent_q [N_ENT];

    always_comb begin
        vld_d = vld_q;
        if (flush) begin
            vld_d = '0;
        end else if (wr_en) begin
            vld_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IW'(g))) begin
                ent_q[g] <= wr_ent;
            end
        end
    end

    always_comb begin
        rd_ent     = ent_q[rd_idx];
        rd_ent.vld = vld_q[rd_idx];
    end

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));

    // R9
    refill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/ptlb_grp_addr.sv
module ptlb_grp_addr
    import ptlb_pkg::*;
(
    input  logic [ADDR_W-1:0] cfg,
    input  logic [HASH_W-1:0] hash,
    input  logic [SLOT_W-1:0] slot,
    input  logic              wsel,
    output logic [ADDR_W-1:0] addr
);
    logic [HASH_W-1:0] mask_full;
    logic [HASH_W-1:0] masked;
    logic [ADDR_W-1:0] grp;

    always_comb begin
        mask_full = {cfg[MASK_W-1:0], {HASH_LOW_W{1'b1}}};
        masked    = hash & mask_full;
        grp       = {cfg[ADDR_W-1 -: BASE_W], {(ADDR_W-BASE_W){1'b0}}}
                  | (ADDR_W'(masked) << GRP_SH);
        addr      = {grp[ADDR_W-1:GRP_SH], slot, wsel, {WSEL_LSB{1'b0}}};
    end
endmodule

// File: rtl/ptlb_walker.sv
module ptlb_walker
    import ptlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VSID_W-1:0] req_vsid,
    input  logic [ADDR_W-1:0] req_ea,
    output logic [IDX_W-1:0]  lk_idx,
    input  tlb_ent_t          lk_ent,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output tlb_ent_t          wr_ent,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [HASH_W-1:0] grp_hash,
    output logic [SLOT_W-1:0] grp_slot,
    output logic              grp_wsel,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_ra,
    output logic [PP_W-1:0]   rsp_pp
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

    typedef struct packed {
        walk_st_t          st;
        logic [VSID_W-1:0] vsid;
        logic [ADDR_W-1:0] ea;
        logic              pass;
        logic [SLOT_W-1:0] slot;
        logic              rsp_vld;
        logic              rsp_flt;
        logic [RPN_W-1:0]  rsp_rpn;
        logic [PP_W-1:0]   rsp_pp;
    } walk_reg_t;

    walk_reg_t d, q;

    logic [PIDX_W-1:0] pidx;
    logic [HASH_W-1:0] hash_pri;
    logic              tlb_hit;
    logic              w0_match;
    logic [RPN_W-1:0]  w1_rpn;
    logic [PP_W-1:0]   w1_pp;

    always_comb begin
        pidx     = q.ea[OFS_W +: PIDX_W];
        hash_pri = q.vsid[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, pidx};
        grp_hash = q.pass ? ~hash_pri : hash_pri;
        grp_slot = q.slot;
        lk_idx   = pidx[IDX_W-1:0];
        tlb_hit  = lk_ent.vld && (lk_ent.vsid == q.vsid) && (lk_ent.pidx == pidx);
        w0_match = mem_rsp_data[DATA_W-1]
                && (mem_rsp_data[DATA_W-2 -: VSID_W] == q.vsid)
                && (mem_rsp_data[API_W] == q.pass)
                && (mem_rsp_data[API_W-1:0] == pidx[PIDX_W-1 -: API_W]);
        w1_rpn   = mem_rsp_data[DATA_W-1 -: RPN_W];
        w1_pp    = mem_rsp_data[PP_W-1:0];
    end

    always_comb begin
        d             = q;
        d.rsp_vld     = 1'b0;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        grp_wsel      = 1'b0;
        wr_en         = 1'b0;
        wr_idx        = pidx[IDX_W-1:0];
        wr_ent        = '{vld: 1'b1, vsid: q.vsid, pidx: pidx, rpn: w1_rpn, pp: w1_pp};
        unique case (q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    d.vsid = req_vsid;
                    d.ea   = req_ea;
                    d.st   = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (tlb_hit) begin
                    d.rsp_vld = 1'b1;
                    d.rsp_flt = 1'b0;
                    d.rsp_rpn = lk_ent.rpn;
                    d.rsp_pp  = lk_ent.pp;
                    d.st      = ST_RESP;
                end else begin
                    d.pass = 1'b0;
                    d.slot = '0;
                    d.st   = ST_RD0;
                end
            end
            ST_RD0: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) d.st = ST_WT0;
            end
            ST_WT0: begin
                if (mem_rsp_valid) begin
                    if (w0_match) begin
                        d.st = ST_RD1;
                    end else if (q.slot != LAST_SLOT) begin
                        d.slot = q.slot + 1'b1;
                        d.st   = ST_RD0;
                    end else if (!q.pass) begin
                        d.pass = 1'b1;
                        d.slot = '0;
                        d.st   = ST_RD0;
                    end else begin
                        d.rsp_vld = 1'b1;
                        d.rsp_flt = 1'b1;
                        d.rsp_rpn = '0;
                        d.rsp_pp  = '0;
                        d.st      = ST_RESP;
                    end
                end
            end
            ST_RD1: begin
                mem_req_valid = 1'b1;
                grp_wsel      = 1'b1;
                if (mem_req_ready) d.st = ST_WT1;
            end
            ST_WT1: begin
                grp_wsel = 1'b1;
                if (mem_rsp_valid) begin
                    wr_en     = 1'b1;
                    d.rsp_vld = 1'b1;
                    d.rsp_flt = 1'b0;
                    d.rsp_rpn = w1_rpn;
                    d.rsp_pp  = w1_pp;
                    d.st      = ST_RESP;
                end
            end
            ST_RESP: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_vld;
    assign rsp_fault = q.rsp_flt;
    assign rsp_ra    = {q.rsp_rpn, q.ea[OFS_W-1:0]};
    assign rsp_pp    = q.rsp_pp;

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

    // R13
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R13
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R12
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R3
    ra_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_ra[OFS_W-1:0] == q.ea[OFS_W-1:0]));
endmodule

// File: rtl/ptlb_hash_xlate.sv
module ptlb_hash_xlate
    import ptlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] cfg_table,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VSID_W-1:0] req_vsid,
    input  logic [ADDR_W-1:0] req_ea,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_ra,
    output logic [PP_W-1:0]   rsp_pp,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    logic [IDX_W-1:0]  lk_idx;
    tlb_ent_t          lk_ent;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    tlb_ent_t          wr_ent;
    logic [HASH_W-1:0] grp_hash;
    logic [SLOT_W-1:0] grp_slot;
    logic              grp_wsel;

    ptlb_array #(.N_ENT(ENTRIES)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .rd_idx (lk_idx),
        .rd_ent (lk_ent),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent)
    );

    ptlb_walker u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vsid      (req_vsid),
        .req_ea        (req_ea),
        .lk_idx        (lk_idx),
        .lk_ent        (lk_ent),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_ent        (wr_ent),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .grp_hash      (grp_hash),
        .grp_slot      (grp_slot),
        .grp_wsel      (grp_wsel),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_ra        (rsp_ra),
        .rsp_pp        (rsp_pp)
    );

    ptlb_grp_addr u_addr (
        .cfg  (cfg_table),
        .hash (grp_hash),
        .slot (grp_slot),
        .wsel (grp_wsel),
        .addr (mem_req_addr)
    );

    // R12
    mem_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

    // R5
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[WSEL_LSB-1:0] == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rsp_valid && !mem_req_valid));
endmodule

// File: tb/ptlb_hash_xlate_tb.sv
module ptlb_hash_xlate_tb_top;
    import ptlb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_main = 1'b0;
    logic        flush_mem;
    logic        flush;
    logic [31:0] cfg_r = {16'h4000, 7'h0, 9'h005};
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vsid = '0;
    logic [31:0] req_ea = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_ra;
    logic [1:0]  rsp_pp;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] pt_mem [logic [31:0]];
    tlb_ent_t    tlb_m [ENTRIES];
    int          rd_total = 0;
    logic [31:0] addr_log [32];
    logic [31:0] mem_a;
    bit          flush_w1 = 0;

    assign flush = flush_main | flush_mem;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptlb_hash_xlate dut_i (
        .clk (clk), .rst_n (rst_n), .flush (flush), .cfg_table (cfg_r),
        .req_valid (req_valid), .req_ready (req_ready), .req_vsid (req_vsid), .req_ea (req_ea),
        .rsp_valid (rsp_valid), .rsp_fault (rsp_fault), .rsp_ra (rsp_ra), .rsp_pp (rsp_pp),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready), .mem_req_addr (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data)
    );

    function automatic logic [31:0] mem_rd(logic [31:0] a);
        return pt_mem.exists(a) ? pt_mem[a] : 32'h0;
    endfunction

    function automatic logic [18:0] hsh(logic [23:0] v, logic [15:0] p);
        return v[18:0] ^ {3'b000, p};
    endfunction

    function automatic logic [31:0] grp(logic [18:0] h);
        logic [18:0] m;
        m = h & {cfg_r[8:0], 10'h3FF};
        return {cfg_r[31:16], 16'h0} | ({13'h0, m} << 6);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_pte(input logic [23:0] v, input logic [15:0] p, input bit pass,
                           input logic [2:0] slot, input logic [19:0] rpn, input logic [1:0] pp);
        logic [18:0] h;
        logic [31:0] a, w;
        h = pass ? ~hsh(v, p) : hsh(v, p);
        a = grp(h) + {26'h0, slot, 3'b000};
        w = mem_rd(a);
        if (w[31]) return;
        pt_mem[a]     = {1'b1, v, pass, p[15:10]};
        pt_mem[a + 4] = {rpn, 10'h0, pp};
    endtask

    task automatic expect_x(input logic [23:0] v, input logic [31:0] ea, output bit flt,
                            output logic [19:0] rpn, output logic [1:0] pp, output int reads);
        logic [15:0] p;
        logic [18:0] h;
        logic [31:0] a, w0, w1;
        p = ea[27:12];
        reads = 0; flt = 1; rpn = '0; pp = '0;
        if (tlb_m[p[5:0]].vld && tlb_m[p[5:0]].vsid == v && tlb_m[p[5:0]].pidx == p) begin
            flt = 0; rpn = tlb_m[p[5:0]].rpn; pp = tlb_m[p[5:0]].pp;
            return;
        end
        for (int ps = 0; ps < 2; ps++) begin
            h = (ps == 1) ? ~hsh(v, p) : hsh(v, p);
            for (int s = 0; s < 8; s++) begin
                a = grp(h) + 32'(s * 8);
                w0 = mem_rd(a);
                reads++;
                if (w0[31] && w0[30:7] == v && w0[6] == 1'(ps) && w0[5:0] == p[15:10]) begin
                    w1 = mem_rd(a + 4);
                    reads++;
                    rpn = w1[31:12]; pp = w1[1:0]; flt = 0;
                    return;
                end
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_main = 1'b1;
        @(negedge clk);
        flush_main = 1'b0;
        for (int i = 0; i < ENTRIES; i++) tlb_m[i].vld = 1'b0;
    endtask

    task automatic access(input logic [23:0] v, input logic [31:0] ea, input string tag,
                          output bit flt_o, output int rd_o, output logic [31:0] fa_o);
        bit eflt, got;
        logic [19:0] erpn;
        logic [1:0] epp;
        int ereads, base;
        bit hit_before;
        logic [15:0] p;
        p = ea[27:12];
        hit_before = tlb_m[p[5:0]].vld && tlb_m[p[5:0]].vsid == v && tlb_m[p[5:0]].pidx == p;
        expect_x(v, ea, eflt, erpn, epp, ereads);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        base = rd_total;
        req_valid = 1'b1; req_vsid = v; req_ea = ea;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; flt_o = 1;
        for (int i = 0; i < 2000; i++) begin
            if (rsp_valid) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
        chk(got, {tag, " response seen"}, 32'(got), 32'd1);
        flt_o = rsp_fault;
        rd_o  = rd_total - base;
        fa_o  = addr_log[base % 32];
        chk(rsp_fault == eflt, {tag, " R8 fault flag"}, 32'(rsp_fault), 32'(eflt));
        if (!eflt) begin
            chk(rsp_ra == {erpn, ea[11:0]}, {tag, " R3 real address"}, rsp_ra, {erpn, ea[11:0]});
            chk(rsp_pp == epp, {tag, " R3 protection"}, 32'(rsp_pp), 32'(epp));
        end
        chk(rd_o == ereads, {tag, " R5 read count"}, 32'(rd_o), 32'(ereads));
        @(negedge clk);
        chk(!rsp_valid && req_ready, {tag, " R13 pulse/idle"}, {30'h0, rsp_valid, req_ready}, 32'h1);
        if (!eflt && !hit_before) begin
            if (flush_w1) begin
                for (int i = 0; i < ENTRIES; i++) tlb_m[i].vld = 1'b0;
            end else begin
                tlb_m[p[5:0]] = '{vld: 1'b1, vsid: v, pidx: p, rpn: erpn, pp: epp};
            end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // memory responder
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        flush_mem     = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                repeat ($urandom % 3) @(negedge clk);
                mem_req_ready = 1'b1;
                mem_a = mem_req_addr;
                addr_log[rd_total % 32] = mem_a;
                rd_total = rd_total + 1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_rd(mem_a);
                flush_mem     = flush_w1 && mem_a[2];
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                flush_mem     = 1'b0;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            finish_run();
        end
    end

    initial begin
        logic [23:0] va, vb, vsid_pool [4];
        logic [15:0] pa, pb, pc, pidx_pool [12];
        logic [31:0] fa, w;
        bit flt;
        int rd;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < ENTRIES; i++) tlb_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
            {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

        va = 24'h3A5C71; pa = 16'h1234;
        put_pte(va, pa, 1'b0, 3'd0, 20'hABCDE, 2'b10);
        access(va, {4'h0, pa, 12'h345}, "R1/R4 cold miss", flt, rd, fa);
        chk(rd == 2, "R5 first-slot reads", 32'(rd), 32'd2);
        chk(fa == grp(hsh(va, pa)), "R4 primary group address", fa, grp(hsh(va, pa)));

        access(va, {4'hF, pa, 12'h0FF}, "R2/R9 repeat hit", flt, rd, fa);
        chk(rd == 0, "R9 hit without memory", 32'(rd), 32'd0);

        access(24'h111111, {4'h0, pa, 12'h010}, "R8 absent page", flt, rd, fa);
        chk(flt == 1'b1, "R8 fault raised", 32'(flt), 32'd1);
        chk(rd == 16, "R8 sixteen reads", 32'(rd), 32'd16);
        access(va, {4'h0, pa, 12'h020}, "R8 no install", flt, rd, fa);
        chk(rd == 0, "R2 slot kept after fault", 32'(rd), 32'd0);

        vb = 24'h0F0F0F; pb = 16'h8421;
        w = grp(hsh(vb, pb)) + 32'd16;
        pt_mem[w] = {1'b1, vb, 1'b1, pb[15:10]};
        put_pte(vb, pb, 1'b1, 3'd5, 20'h13579, 2'b01);
        access(vb, {4'h2, pb, 12'hABC}, "R6/R7 secondary", flt, rd, fa);
        chk(rd == 15, "R7 secondary slot5 reads", 32'(rd), 32'd15);

        pc = 16'hF234;
        put_pte(va, pc, 1'b0, 3'd3, 20'h55555, 2'b11);
        access(va, {4'h0, pc, 12'h777}, "R10 conflicting page", flt, rd, fa);
        access(va, {4'h0, pa, 12'h001}, "R10 evicted page", flt, rd, fa);
        chk(rd != 0, "R10 evicted page walks", 32'(rd), 32'd2);

        access(va, {4'h0, pa, 12'h002}, "R11 before flush", flt, rd, fa);
        do_flush();
        access(va, {4'h0, pa, 12'h003}, "R11 after flush", flt, rd, fa);
        chk(rd == 2, "R11 flush forces walk", 32'(rd), 32'd2);
        do_flush();
        flush_w1 = 1;
        access(va, {4'h0, pa, 12'h004}, "R11 flush at refill", flt, rd, fa);
        flush_w1 = 0;
        access(va, {4'h0, pa, 12'h005}, "R11 refill dropped", flt, rd, fa);
        chk(rd == 2, "R11 flush beats refill", 32'(rd), 32'd2);

        for (int i = 0; i < 4; i++) vsid_pool[i] = 24'($urandom);
        for (int i = 0; i < 12; i++) begin
            pidx_pool[i] = 16'($urandom);
            pidx_pool[i][5:0] = 6'(8 + (i % 3));
        end
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 12; j++) begin
                if ($urandom % 2 == 0)
                    put_pte(vsid_pool[i], pidx_pool[j], 1'($urandom), 3'($urandom),
                            20'($urandom), 2'($urandom));
            end
        end
        for (int k = 0; k < 250; k++) begin
            if ($urandom % 25 == 0) do_flush();
            access(vsid_pool[$urandom % 4],
                   {4'($urandom), pidx_pool[$urandom % 12], 12'($urandom)},
                   "R2/R9 random", flt, rd, fa);
        end

        done = 1;
        finish_run();
    end
endmodule